// File: doc/BRIEF.md
# Oscillator Stop Detector with Sticky Status Flags

This block watches one or more free-running oscillator clocks from a trusted reference clock. Each monitored clock is brought into the reference domain through a synchronizer, where its rising edges are found. A per-channel counter measures how many reference cycles have passed since the last such edge. When the channel's oscillator is enabled and the count reaches the selected timeout, a sticky "clock missing" flag is raised. At the same moment, a one-cycle stop-detection request is sent to the reset logic.

Each channel picks one of two timeout lengths with its own select bit. The flags are deliberately left out of the reset, so the evidence of a clock failure survives the reset that the failure itself may trigger. Software clears the flags only by reading the clear-on-read status alias. The flags appear in a 16-bit status word: channel 0 (main oscillator) drives bit 14 and channel 1 (sub oscillator) drives bit 15.

Top module: `clkstop_monitor`

## Requirements
- R1: With `tmo_sel[i]`=0, the oscillator enabled and no rising edge on `mon_clk[i]`, the flag of channel i is 0 after 255 reference edges counted from the edge that first samples `osc_en[i]`=1. It is 1 after the 256th edge.
- R2: With `tmo_sel[i]`=1, the same interval is 4096 reference edges. The flag is still 0 after 4095 edges.
- R3: Any rising edge on `mon_clk[i]` restarts the interval. A rise applied between reference edges gives a flag that is still 0 after T+2 edges and 1 after T+3 edges, where T is the selected interval. A clock whose period is well below T never raises the flag.
- R4: While `osc_en[i]`=0 the flag is never set, even with no clock edges at all. The count is cleared, so the next enable starts a full interval.
- R5: `rst_n` low does not change any flag, and `stop_req` is 0 while `rst_n` is low.
- R6: A cycle with `rd_en`=1 and `rd_addr`=24'h00040B clears every flag on that edge. A read of any other address leaves the flags unchanged.
- R7: If a timeout and a clearing read fall on the same edge, the flag ends up 1.
- R8: `stop_req[i]` is high for exactly one cycle: the first cycle in which flag i reads 1. While the flag stays set, a later timeout of the same silent gap produces no new pulse.
- R9: `status_word` carries the channel 0 flag at bit 14 and the channel 1 flag at bit 15. All other bits are 0. The two channels run independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset of synchronizers, counters and request outputs (not the flags) |
| mon_clk | input | NUM_CH | Monitored oscillator clocks, asynchronous |
| osc_en | input | NUM_CH | Oscillator enable per channel, reference domain |
| tmo_sel | input | NUM_CH | Interval select per channel: 0 short, 1 long |
| rd_en | input | 1 | Status read strobe |
| rd_addr | input | ADDR_W | Byte address of the status read |
| status_word | output | STAT_W | Flag status word |
| stop_req | output | NUM_CH | One-cycle clock-stop request per channel |

## Verification
Each result has a fixed due time:
- A timeout flag appears on the T-th reference edge after the enable is sampled.
- When the count restarts from a monitored rise, the flag appears three edges later than that: two for the synchronizer and one for the edge detector.
- A clearing read takes effect on the edge that samples it.
- The stop request is valid in the same cycle as the new flag.

The bench drives every input on the falling edge and counts rising edges from that point. It samples one edge before and exactly at the due edge, so a result that comes early or late is caught. The random phases hold each monitored period well below the short interval. Any flag or request seen in those phases is therefore an error.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

   // Interval select encoding, one bit per channel
   typedef enum logic {
      TMO_SHORT = 1'b0,
      TMO_LONG  = 1'b1
   } tmo_sel_e;

   // Width of a counter that must hold values up to max_val
   function automatic int cnt_width(input int max_val);
      return $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkstop_sync: STAGES must be at least 2");
   end

   // Synchronizer chain plus one extra flop for edge history
   logic [STAGES:0] chain_q;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R3: a detected rise lasts a single reference cycle
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/clkstop_timer.sv
module clkstop_timer #(
   parameter int SHORT_TMO = 256,
   parameter int LONG_TMO  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rise,
   input  logic sel,
   output logic expire
);

   import clkstop_pkg::*;

   localparam int CNT_W = cnt_width(LONG_TMO);
   localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_TMO - 1);
   localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_TMO - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LONG_TMO);

   if (SHORT_TMO < 2) begin : g_bad_short
      $error("clkstop_timer: SHORT_TMO must be at least 2");
   end
   if (LONG_TMO <= SHORT_TMO) begin : g_bad_long
      $error("clkstop_timer: LONG_TMO must exceed SHORT_TMO");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             trip_q, trip_d;
   logic [CNT_W-1:0] thr;

   always_comb begin
      thr = (tmo_sel_e'(sel) == TMO_LONG) ? LONG_M1 : SHORT_M1;
   end

   // One expiry per silent gap; trip_q blocks repeats until an edge or disable
   always_comb begin
      expire = en && !rise && !trip_q && (cnt_q >= thr);
   end

   always_comb begin
      cnt_d  = cnt_q;
      trip_d = trip_q;
      if (!en || rise) begin
         cnt_d  = '0;
         trip_d = 1'b0;
      end else begin
         if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
         if (expire)           trip_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trip_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         trip_q <= trip_d;
      end
   end

   // R4
   cnt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));

   // R3
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rise) |=> (cnt_q == '0));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

endmodule

// File: rtl/clkstop_flag.sv
module clkstop_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag,
   output logic stop_req
);

   logic flag_q;
   logic req_q;

   // Sticky flag: deliberately outside the reset, set wins over clear
   always_ff @(posedge clk) begin
      flag_q <= set | (flag_q & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= set & ~flag_q;
   end

   assign flag     = flag_q;
   assign stop_req = req_q;

   // R8
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   // R8
   req_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> flag_q);

endmodule

// File: rtl/clkstop_monitor.sv
module clkstop_monitor #(
   parameter int              NUM_CH      = 2,
   parameter int              SYNC_STAGES = 2,
   parameter int              SHORT_TMO   = 256,
   parameter int              LONG_TMO    = 4096,
   parameter int              ADDR_W      = 24,
   parameter logic [23:0]     CLR_ADDR    = 24'h00040B,
   parameter int              STAT_W      = 16,
   parameter int              STAT_LSB    = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] mon_clk,
   input  logic [NUM_CH-1:0] osc_en,
   input  logic [NUM_CH-1:0] tmo_sel,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [STAT_W-1:0] status_word,
   output logic [NUM_CH-1:0] stop_req
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("clkstop_monitor: NUM_CH must be at least 1");
   end
   if (STAT_LSB + NUM_CH > STAT_W) begin : g_bad_stat
      $error("clkstop_monitor: flag bits do not fit in the status word");
   end
   if (ADDR_W > 24 || ADDR_W < 1) begin : g_bad_addr
      $error("clkstop_monitor: ADDR_W must be 1..24");
   end

   localparam logic [ADDR_W-1:0] CLR_MATCH = CLR_ADDR[ADDR_W-1:0];

   logic              rd_hit;
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] expire;
   logic [NUM_CH-1:0] flag;

   assign rd_hit = rd_en && (rd_addr == CLR_MATCH);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      clkstop_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (mon_clk[i]),
         .rise     (rise[i])
      );

      clkstop_timer #(
         .SHORT_TMO (SHORT_TMO),
         .LONG_TMO  (LONG_TMO)
      ) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (osc_en[i]),
         .rise   (rise[i]),
         .sel    (tmo_sel[i]),
         .expire (expire[i])
      );

      clkstop_flag u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .set      (expire[i]),
         .clr      (rd_hit),
         .flag     (flag[i]),
         .stop_req (stop_req[i])
      );

      // R6
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_hit && !expire[i]) |=> !flag[i]);

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         expire[i] |=> flag[i]);

      // R4
      enabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(osc_en[i]));
   end

   always_comb begin
      status_word = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         status_word[STAT_LSB + i] = flag[i];
      end
   end

endmodule

// File: tb/tb_clkstop_monitor.sv
module tb_clkstop_monitor;

   localparam int NUM_CH = 2;
   localparam int ADDR_W = 24;
   localparam logic [ADDR_W-1:0] CLR = 24'h00040B;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] mon_clk;
   logic [NUM_CH-1:0] osc_en = '0;
   logic [NUM_CH-1:0] tmo_sel = '0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [15:0]       status_word;
   logic [NUM_CH-1:0] stop_req;

   // monitored clock sources: free toggler or held level
   logic [NUM_CH-1:0] tog_on = '0;
   logic [NUM_CH-1:0] tog_q = '0;
   logic [NUM_CH-1:0] hold = '0;
   int                half [NUM_CH];
   int                ph   [NUM_CH];

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;   // 250 MHz

   assign mon_clk = (tog_on & tog_q) | (~tog_on & hold);

   always @(negedge clk) begin
      for (int i = 0; i < NUM_CH; i++) begin
         if (ph[i] <= 0) begin
            tog_q[i] <= ~tog_q[i];
            ph[i]    <= half[i] - 1;
         end else begin
            ph[i] <= ph[i] - 1;
         end
      end
   end

   clkstop_monitor dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mon_clk     (mon_clk),
      .osc_en      (osc_en),
      .tmo_sel     (tmo_sel),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .status_word (status_word),
      .stop_req    (stop_req)
   );

   function automatic int exp_tmo(input logic sel);
      return sel ? 4096 : 256;
   endfunction

   function automatic logic [15:0] exp_word(input logic f0, input logic f1);
      return {f1, f0, 14'b0};
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_read();
      rd_en   = 1'b1;
      rd_addr = CLR;
      step(1);
      rd_en   = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int t;
      int errs;
      logic [ADDR_W-1:0] a;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NUM_CH; i++) begin
         half[i] = 8;
         ph[i]   = 0;
      end
      step(4);
      chk("R5 stop_req low in reset", 32'(stop_req), 32'd0);
      rst_n = 1'b1;
      step(2);
      clear_read();
      chk("R9 status word after clear", 32'(status_word), 32'h0);

      // R1: short interval on channel 0
      t = exp_tmo(1'b0);
      tmo_sel[0] = 1'b0;
      osc_en[0]  = 1'b1;
      step(t - 1);
      chk("R1 flag not early", 32'(status_word[14]), 32'd0);
      chk("R8 no early request", 32'(stop_req[0]), 32'd0);
      step(1);
      chk("R1 flag at interval", 32'(status_word[14]), 32'd1);
      chk("R8 request with new flag", 32'(stop_req[0]), 32'd1);
      chk("R9 main flag at bit 14", 32'(status_word), 32'(exp_word(1'b1, 1'b0)));
      step(1);
      chk("R8 request one cycle", 32'(stop_req[0]), 32'd0);
      chk("R1 flag sticky", 32'(status_word[14]), 32'd1);
      osc_en[0] = 1'b0;

      // R5: reset keeps the flag
      rst_n = 1'b0;
      step(3);
      chk("R5 flag kept during reset", 32'(status_word[14]), 32'd1);
      chk("R5 stop_req low in reset", 32'(stop_req), 32'd0);
      rst_n = 1'b1;
      step(2);
      chk("R5 flag kept after reset", 32'(status_word[14]), 32'd1);

      // R6: other addresses do not clear, the alias does
      rd_en = 1'b1;
      rd_addr = CLR - 1'b1;
      step(1);
      rd_addr = CLR + 1'b1;
      step(1);
      rd_en = 1'b0;
      chk("R6 other address ignored", 32'(status_word[14]), 32'd1);
      clear_read();
      chk("R6 clear-on-read", 32'(status_word[14]), 32'd0);

      // R3: a rise restarts the interval
      hold[0] = 1'b0;
      osc_en[0] = 1'b1;
      step(100);
      hold[0] = 1'b1;
      step(t + 2);
      chk("R3 no flag T+2 after rise", 32'(status_word[14]), 32'd0);
      step(1);
      chk("R3 flag T+3 after rise", 32'(status_word[14]), 32'd1);
      osc_en[0] = 1'b0;
      hold[0] = 1'b0;
      step(1);
      clear_read();

      // R4: disabled never flags; re-enable restarts a full interval
      osc_en[0] = 1'b1;
      step(200);
      osc_en[0] = 1'b0;
      step(1);
      errs = 0;
      for (int k = 0; k < 5000; k++) begin
         if (status_word != 16'h0 || stop_req != '0) errs++;
         step(1);
      end
      chk("R4 no flag while disabled", 32'(errs), 32'd0);
      osc_en[0] = 1'b1;
      step(t - 1);
      chk("R4 full interval after re-enable", 32'(status_word[14]), 32'd0);
      step(1);
      chk("R4 flag after full interval", 32'(status_word[14]), 32'd1);
      osc_en[0] = 1'b0;
      step(1);
      clear_read();

      // R7: timeout and clearing read on the same edge
      osc_en[0] = 1'b1;
      step(t - 1);
      rd_en = 1'b1;
      rd_addr = CLR;
      step(1);
      rd_en = 1'b0;
      chk("R7 set wins over clear", 32'(status_word[14]), 32'd1);
      osc_en[0] = 1'b0;
      step(1);
      clear_read();

      // R2: long interval on channel 1, channel 0 untouched
      t = exp_tmo(1'b1);
      tmo_sel[1] = 1'b1;
      osc_en[1] = 1'b1;
      step(t - 1);
      chk("R2 flag not early", 32'(status_word[15]), 32'd0);
      step(1);
      chk("R2 flag at long interval", 32'(status_word[15]), 32'd1);
      chk("R9 sub flag at bit 15 only", 32'(status_word), 32'(exp_word(1'b0, 1'b1)));
      chk("R8 request on sub only", 32'(stop_req), 32'b10);
      errs = 0;
      step(1);
      for (int k = 0; k < 300; k++) begin
         if (stop_req != '0) errs++;
         step(1);
      end
      chk("R8 no repeat request", 32'(errs), 32'd0);
      osc_en[1] = 1'b0;
      step(1);
      clear_read();

      // R3/R6/R9: random clock periods below the short interval, random reads
      for (int trial = 0; trial < 4; trial++) begin
         for (int i = 0; i < NUM_CH; i++) half[i] = 2 + int'($urandom % 40);
         tog_on  = '1;
         tmo_sel = NUM_CH'($urandom);
         step(4);
         osc_en = '1;
         errs = 0;
         for (int k = 0; k < 1500; k++) begin
            a = ADDR_W'($urandom);
            if (a == CLR) a = a ^ 24'h1;
            rd_en   = ($urandom % 3) == 0;
            rd_addr = a;
            step(1);
            if (status_word != 16'h0 || stop_req != '0) errs++;
         end
         rd_en = 1'b0;
         chk("R3 running clocks never flag", 32'(errs), 32'd0);
         osc_en = '0;
         tog_on = '0;
         step(2);
      end

      // R9: both flags together
      tmo_sel = '0;
      osc_en  = '1;
      step(exp_tmo(1'b0));
      chk("R9 both flags", 32'(status_word), 32'(exp_word(1'b1, 1'b1)));
      osc_en = '0;
      step(1);
      clear_read();
      chk("R6 clear both", 32'(status_word), 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule